// File: doc/BRIEF.md
# Periodic Rate Generator

This block turns a fast timebase into a programmable periodic tick. A free-running binary divider advances once for each cycle on which the timebase enable is high. A 4-bit rate code picks one divider stage as a square-wave level. Each step of the code halves the frequency, and code zero switches the output off. A one-cycle event pulse marks every rising edge of that level. Two enable bits gate the level onto the square-wave pin and the pulse onto the interrupt request.

A 3-bit divider-control field sits next to the rate code in the first configuration register. Two of its codes hold the divider in reset, which software uses to restart the phase of the tick. The remaining codes let the divider run. The three codes that name a reference frequency do not change the counting here, because the timebase enable is expected to arrive at the correct rate already.

Top module: `tick_rate_gen`

## Requirements
- R1: While reset is asserted the divider count is zero and `evt_pulse`, `sqw_out` and `pint_req` are all low.
- R2: The divider count rises by one (wrapping within its 15 bits) on each clock where `tick_en` is high and the divider is not held; on any other unheld clock it keeps its value.
- R3: For a rate code n from 1 to 15 the selected level equals bit n-1 of the divider count, so with `tick_en` at 65,536 Hz code 1 gives 32,768 Hz and code 15 gives 2 Hz.
- R4: With rate code 0 the selected level is low, no event pulse or interrupt request appears, and the divider keeps counting.
- R5: With `div_ctl` equal to 6 or 7 the divider is cleared to zero on every clock, and the selected level, `evt_pulse`, `sqw_out` and `pint_req` stay low.
- R6: With `div_ctl` from 0 to 5 the divider runs as in R2. Codes 0, 1 and 2 name reference clocks of 4.194 MHz, 1.049 MHz and 32.768 kHz and have no other effect.
- R7: `evt_pulse` is high for exactly the clocks on which the selected level is 1 and was 0 on the previous clock. This holds whatever the two enable bits are.
- R8: `pint_req` equals `evt_pulse` while `pint_enable` (bit 6 of the second configuration register) is high, and is low otherwise.
- R9: `sqw_out` equals the selected level while `sqw_enable` (bit 3 of the second configuration register) is high, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Timebase enable, one clock per divider step |
| rate_code | input | 4 | Rate select, bits 3:0 of the first configuration register |
| div_ctl | input | 3 | Divider control, bits 6:4 of the first configuration register |
| sqw_enable | input | 1 | Square-wave enable, bit 3 of the second configuration register |
| pint_enable | input | 1 | Periodic interrupt enable, bit 6 of the second configuration register |
| evt_pulse | output | 1 | One-clock pulse on each rising edge of the selected level |
| sqw_out | output | 1 | Gated square-wave level |
| pint_req | output | 1 | Gated periodic interrupt request |

## Verification
The slowest rates are the hardest to reach from the ports. Code 15 shows its first rising edge only after 16,384 divider steps. The stimulus therefore clears the divider through a hold code before every rate and then runs each slow rate just past its first full period. Rate changes on a live divider are also driven, and so is a hold code asserted in the middle of a run. Both can create or suppress an edge, and the bench follows them with its own step count and the level it predicted for the previous clock.

// File: rtl/tick_pkg.sv
package tick_pkg;

  // Divider-control codes that keep the divider chain in reset.
  localparam int unsigned DCTL_W       = 3;
  localparam logic [2:0]  DCTL_HOLD_LO = 3'd6;
  localparam logic [2:0]  DCTL_HOLD_HI = 3'd7;

  // True when the divider-control code holds the chain in reset.
  function automatic logic chain_held(input logic [DCTL_W-1:0] dctl);
    return (dctl == DCTL_HOLD_LO) || (dctl == DCTL_HOLD_HI);
  endfunction

  // A tap drives the output only for a nonzero code on a running chain.
  function automatic logic tap_enabled(input logic code_nonzero, input logic held);
    return code_nonzero && !held;
  endfunction

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int unsigned DIV_W = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step_en,
  input  logic             hold,
  output logic [DIV_W-1:0] count
);

  localparam logic [DIV_W-1:0] STEP = DIV_W'(1);

  // Next divider value: a hold clears, an enabled step increments.
  function automatic logic [DIV_W-1:0] next_count(
    input logic [DIV_W-1:0] cur,
    input logic             en,
    input logic             clr
  );
    if (clr)     return '0;
    else if (en) return cur + STEP;
    else         return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count <= '0;
    else        count <= next_count(count, step_en, hold);
  end

endmodule

// File: rtl/tick_tap.sv
module tick_tap #(
  parameter int unsigned RATE_W = 4,
  parameter int unsigned DIV_W  = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  count,
  input  logic [RATE_W-1:0] code,
  input  logic              active,
  output logic              level,
  output logic              rise
);

  localparam int unsigned NTAP = 1 << RATE_W;

  logic [NTAP-1:0] taps;
  logic            level_q;

  // Code 0 has no stage; code g reads divider bit g-1.
  assign taps[0] = 1'b0;
  for (genvar g = 1; g < NTAP; g++) begin : g_tap
    if (g - 1 < DIV_W) begin : g_bit
      assign taps[g] = count[g-1];
    end else begin : g_none
      assign taps[g] = 1'b0;
    end
  end

  assign level = active ? taps[code] : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= 1'b0;
    else        level_q <= level;
  end

  assign rise = level && !level_q;

endmodule

// File: rtl/tick_rate_gen.sv
module tick_rate_gen
  import tick_pkg::*;
#(
  parameter int unsigned RATE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_en,
  input  logic [RATE_W-1:0] rate_code,
  input  logic [2:0]        div_ctl,
  input  logic              sqw_enable,
  input  logic              pint_enable,
  output logic              evt_pulse,
  output logic              sqw_out,
  output logic              pint_req
);

  // One divider stage per nonzero rate code.
  localparam int unsigned DIV_W = (1 << RATE_W) - 1;

  logic             chain_hold;
  logic             tap_active;
  logic             tap_level;
  logic             tap_rise;
  logic [DIV_W-1:0] div_count;

  assign chain_hold = chain_held(div_ctl);
  assign tap_active = tap_enabled(rate_code != '0, chain_hold);

  tick_divider #(
    .DIV_W (DIV_W)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .step_en (tick_en),
    .hold    (chain_hold),
    .count   (div_count)
  );

  tick_tap #(
    .RATE_W (RATE_W),
    .DIV_W  (DIV_W)
  ) u_tap (
    .clk    (clk),
    .rst_n  (rst_n),
    .count  (div_count),
    .code   (rate_code),
    .active (tap_active),
    .level  (tap_level),
    .rise   (tap_rise)
  );

  assign evt_pulse = tap_rise;
  assign sqw_out   = tap_level && sqw_enable;
  assign pint_req  = tap_rise && pint_enable;

endmodule

// File: rtl/tick_rate_chk.sv
module tick_rate_chk #(
  parameter int unsigned RATE_W = 4,
  parameter int unsigned DIV_W  = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_en,
  input logic [RATE_W-1:0] rate_code,
  input logic [2:0]        div_ctl,
  input logic              sqw_enable,
  input logic              pint_enable,
  input logic              evt_pulse,
  input logic              sqw_out,
  input logic              pint_req,
  input logic [DIV_W-1:0]  div_count,
  input logic              tap_level
);

  logic             held_c;
  logic [DIV_W-1:0] count_plus;

  assign held_c     = (div_ctl == 3'd6) || (div_ctl == 3'd7);
  assign count_plus = div_count + DIV_W'(1);

  AST_HOLD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    held_c |=> (div_count == '0)); // R5
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    held_c |-> (!evt_pulse && !sqw_out && !tap_level)); // R5
  AST_RATE0_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (rate_code == '0) |-> (!evt_pulse && !sqw_out && !pint_req)); // R4
  AST_IDLE_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_en && !held_c) |=> $stable(div_count)); // R2
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !held_c) |=> (div_count == $past(count_plus))); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |=> !evt_pulse); // R7
  AST_PULSE_ON_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    evt_pulse |-> tap_level); // R7
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pint_req |-> (evt_pulse && pint_enable)); // R8
  AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_pulse && pint_enable) |-> pint_req); // R8
  AST_SQW_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    !sqw_enable |-> !sqw_out); // R9

endmodule

bind tick_rate_gen tick_rate_chk #(
  .RATE_W (RATE_W),
  .DIV_W  (DIV_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .tick_en     (tick_en),
  .rate_code   (rate_code),
  .div_ctl     (div_ctl),
  .sqw_enable  (sqw_enable),
  .pint_enable (pint_enable),
  .evt_pulse   (evt_pulse),
  .sqw_out     (sqw_out),
  .pint_req    (pint_req),
  .div_count   (div_count),
  .tap_level   (tap_level)
);

// File: tb/sim_tick_rate_gen.sv
`timescale 1ns/1ps
module sim_tick_rate_gen;

  localparam int RW       = 4;
  localparam int CW       = 15;
  localparam int WD_LIMIT = 190000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       tick_en = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic [2:0] div_ctl = 3'd0;
  logic       sqw_enable = 1'b0;
  logic       pint_enable = 1'b0;
  wire        evt_pulse;
  wire        sqw_out;
  wire        pint_req;

  int          checks = 0;
  int          failures = 0;
  bit          done = 1'b0;
  int unsigned k_m = 0;     // divider steps since last clear
  bit          prev_m = 1'b0; // level predicted for the previous clock

  always #2 clk = ~clk;

  tick_rate_gen #(.RATE_W(RW)) u0 (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick_en     (tick_en),
    .rate_code   (rate_code),
    .div_ctl     (div_ctl),
    .sqw_enable  (sqw_enable),
    .pint_enable (pint_enable),
    .evt_pulse   (evt_pulse),
    .sqw_out     (sqw_out),
    .pint_req    (pint_req)
  );

  // Level from the requirements: bit n-1 of the step count, zero when idle.
  function automatic bit model_level(int unsigned k, int r, int d);
    if (r == 0 || d >= 6) return 1'b0;
    return ((k >> (r - 1)) % 2) == 1;
  endfunction

  function automatic int run_len(int r);
    if (r <= 11) return 3000;
    return (1 << r) + 400;
  endfunction

  task automatic chk(string tag, string what, bit act, bit exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0b expected=%0b (k=%0d rate=%0d ctl=%0d)",
               tag, what, act, exp, k_m, rate_code, div_ctl);
    end
  endtask

  // Inputs are set just after a falling edge; compare, advance model, wait.
  task automatic step(string tag);
    bit lv;
    bit ev;
    #1;
    lv = model_level(k_m, int'(rate_code), int'(div_ctl));
    ev = lv && !prev_m;
    chk(tag, "sqw_out",   sqw_out,   lv && sqw_enable);
    chk(tag, "evt_pulse", evt_pulse, ev);
    chk(tag, "pint_req",  pint_req,  ev && pint_enable);
    prev_m = lv;
    if (div_ctl >= 3'd6)  k_m = 0;
    else if (tick_en)     k_m = (k_m + 1) % (1 << CW);
    @(negedge clk);
  endtask

  initial begin
    #(4 * WD_LIMIT);
    if (!done) begin
      failures++;
      $display("FAIL watchdog all requirements actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    string tg;
    // R1: reset state with a fast rate and both enables set
    rate_code = 4'd1; div_ctl = 3'd0; sqw_enable = 1'b1; pint_enable = 1'b1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "sqw_out",   sqw_out,   1'b0);
    chk("R1", "evt_pulse", evt_pulse, 1'b0);
    chk("R1", "pint_req",  pint_req,  1'b0);
    rst_n = 1'b1;
    k_m = 0; prev_m = 1'b0;
    step("R1");
    step("R1");

    // R3 R6: every rate from a cleared divider, control code cycling 0..5
    for (int r = 0; r < 16; r++) begin
      rate_code = r[3:0]; div_ctl = 3'd6; tick_en = 1'b1;
      sqw_enable = 1'b1; pint_enable = r[0];
      step("R5");
      div_ctl = 3'(r % 6);
      tg = (r == 0) ? "R4" : "R3 R6";
      for (int i = 0; i < run_len(r); i++) step(tg);
    end

    // R2: timebase enable low on every third clock
    rate_code = 4'd2; div_ctl = 3'd2; pint_enable = 1'b1;
    for (int i = 0; i < 600; i++) begin
      tick_en = (i % 3) != 0;
      step("R2");
    end
    tick_en = 1'b1;

    // R4: code 0 while the divider keeps counting, then a live switch to 4
    rate_code = 4'd0;
    for (int i = 0; i < 300; i++) step("R4");
    rate_code = 4'd4;
    for (int i = 0; i < 300; i++) step("R4 R3");

    // R5: hold codes 7 and 6 in the middle of a fast run
    rate_code = 4'd1; div_ctl = 3'd1;
    for (int i = 0; i < 50; i++) step("R3");
    div_ctl = 3'd7;
    for (int i = 0; i < 20; i++) step("R5");
    div_ctl = 3'd1;
    for (int i = 0; i < 37; i++) step("R5 R2");
    div_ctl = 3'd6;
    for (int i = 0; i < 5; i++) step("R5");
    div_ctl = 3'd0;
    for (int i = 0; i < 40; i++) step("R5 R2");

    // R7 R8 R9: the pulse runs on with each enable off in turn
    rate_code = 4'd3; sqw_enable = 1'b0; pint_enable = 1'b0;
    for (int i = 0; i < 200; i++) step("R7 R8 R9");
    sqw_enable = 1'b1;
    for (int i = 0; i < 100; i++) step("R7 R9");
    sqw_enable = 1'b0; pint_enable = 1'b1;
    for (int i = 0; i < 100; i++) step("R7 R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule